// File: doc/BRIEF.md
# Serial Command Memory Slave

This block is the device side of a four-wire serial link in clock mode 0. It serves a byte-addressed store that is 8K locations deep. Chip select is active low. A host frames each command by pulling chip select low and sends an eight-bit op-code, most significant bit first. Some op-codes carry a payload. The block can read or write a one-byte status word, or stream bytes into or out of the store. Streaming begins at a two-byte start address and steps the address after every byte.

A write-arm flag guards every write. Only its own arm op-code sets it. The flag shows as bit 1 of the status word, and the status-write command cannot set it. When chip select rises at the end of a disarm, status-write or memory-write frame, the flag clears. Each write therefore needs its own arm frame first. A memory write or status write that starts with the flag clear changes nothing.

The serial pins are sampled on the system clock through a synchronizer, so the serial clock must run well below the system clock. The output pin has an enable that is high only while a read phase drives it. The storage depth is a parameter. Addresses above that depth alias onto the low bits.

Top module: `spi_cmd_mem_slave`

## Requirements
- R1: Every byte moves most significant bit first. MOSI is captured on the rising serial clock edge. MISO changes only after a falling serial clock edge, so each read bit is stable at the next rising edge.
- R2: The op-code values are: 0x06 arm, 0x04 disarm, 0x05 status read, 0x01 status write, 0x03 memory read, 0x02 memory write.
- R3: After reset the status word reads 0x00. Bit 1 of the status word is the write-arm flag. All other bits always read 0.
- R4: Op-code 0x06 sets the write-arm flag. The flag becomes visible in the next status read, and no other op-code sets it.
- R5: A status-write payload never sets the write-arm flag, whatever the payload bits are.
- R6: The write-arm flag is 0 after chip select rises at the end of a frame whose op-code was 0x04, 0x01 or 0x02.
- R7: A memory write stores its data bytes only if the write-arm flag was set when its op-code arrived. Otherwise the store is unchanged.
- R8: Memory read and memory write take a high address byte and then a low address byte. The top 3 bits of the high byte are ignored, which leaves a 13-bit address. The address steps by one after every data byte and wraps from 0x1FFF to 0x0000.
- R9: An undefined op-code makes the block ignore every following byte until chip select rises. The output enable stays low during that time.
- R10: If chip select rises in the middle of a byte, the partial byte is dropped, and the next frame starts byte alignment from its first bit.
- R11: spi_miso_oe is high only during the data phase of a status read or memory read with chip select low. It is low from reset and after each frame ends.
- R12: Only the low MEM_AW address bits select a storage location. Higher bits alias onto the same location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is clocked here |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | High when spi_miso should be driven onto the line |

## Verification
The bench builds the block with ADDR_W=13 and MEM_AW=6, which gives a 64-byte store. With that depth, one write burst and one read burst cover every location with an arithmetic pattern. Address 0x1FFF and the wrap to 0x0000 sit inside a two-byte burst, and addresses above 63 reach the aliasing rule. The small frame cost also allows a sweep over all 250 undefined op-codes, each followed by an embedded arm byte, with a status read after each one.

// File: rtl/spi_mem_pkg.sv
`timescale 1ns/1ps
package spi_mem_pkg;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  localparam int ARM_BIT = 1;

  typedef enum logic [2:0] {
    ST_OPC     = 3'd0,
    ST_ADDR_HI = 3'd1,
    ST_ADDR_LO = 3'd2,
    ST_RD      = 3'd3,
    ST_WR      = 3'd4,
    ST_SR_RD   = 3'd5,
    ST_SR_WR   = 3'd6,
    ST_SKIP    = 3'd7
  } ctrl_state_e;

endpackage

// File: rtl/spi_bit_rx.sv
`timescale 1ns/1ps
module spi_bit_rx #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              sck_fall,
  output logic              cs_active,
  output logic              cs_end,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  // each stage holds {sck, cs_n, mosi}
  logic [SYNC_STAGES-1:0][2:0] sync_q;
  logic sck_s, cs_s, mosi_s;
  logic sck_d, cs_d;
  logic sck_rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 3'b010;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sync_q[0] <= {sck, cs_n, mosi};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  assign sck_s  = sync_q[SYNC_STAGES-1][2];
  assign cs_s   = sync_q[SYNC_STAGES-1][1];
  assign mosi_s = sync_q[SYNC_STAGES-1][0];

  assign cs_active = ~cs_s;
  assign cs_end    = cs_s & ~cs_d;
  assign sck_rise  = sck_s & ~sck_d & ~cs_s;
  assign sck_fall  = ~sck_s & sck_d & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (cs_s) begin
        bit_cnt <= '0;
        shreg   <= '0;
      end else if (sck_rise) begin
        shreg   <= {shreg[BYTE_W-3:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          byte_valid <= 1'b1;
          byte_data  <= {shreg, mosi_s};
          bit_cnt    <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/spi_byte_tx.sv
`timescale 1ns/1ps
module spi_byte_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              shift,
  output logic              tx_bit
);

  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      tx_bit <= 1'b0;
    end else if (load) begin
      shreg <= load_data;
    end else if (shift) begin
      tx_bit <= shreg[BYTE_W-1];
      shreg  <= {shreg[BYTE_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/spi_mem_store.sv
`timescale 1ns/1ps
module spi_mem_store #(
  parameter int MEM_AW = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MEM_AW-1:0] wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [MEM_AW-1:0] rd_idx,
  output logic [BYTE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << MEM_AW;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/spi_mem_ctrl.sv
`timescale 1ns/1ps
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int MEM_AW = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              cs_end,
  input  logic [BYTE_W-1:0] mem_rd_data,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_data,
  output logic              miso_oe,
  output logic              wel,
  output logic              clr_pending,
  output ctrl_state_e       state,
  output logic [ADDR_W-1:0] addr,
  output logic              mem_we,
  output logic [MEM_AW-1:0] wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic [MEM_AW-1:0] rd_idx
);

  localparam int HI_W = ADDR_W - BYTE_W;

  logic              is_write;
  logic              armed;
  logic              take;
  logic [MEM_AW-1:0] lo_idx;
  logic [BYTE_W-1:0] status_byte;

  assign take = byte_valid & ~cs_end;

  // index of the first read location while the low address byte arrives
  generate
    if (MEM_AW <= BYTE_W) begin : g_idx_narrow
      assign lo_idx = byte_data[MEM_AW-1:0];
    end else begin : g_idx_wide
      assign lo_idx = {addr[MEM_AW-1:BYTE_W], byte_data};
    end
  endgenerate

  always_comb begin
    status_byte = '0;
    status_byte[ARM_BIT] = wel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_OPC;
      addr        <= '0;
      wel         <= 1'b0;
      clr_pending <= 1'b0;
      armed       <= 1'b0;
      is_write    <= 1'b0;
      miso_oe     <= 1'b0;
    end else if (cs_end) begin
      state       <= ST_OPC;
      miso_oe     <= 1'b0;
      armed       <= 1'b0;
      clr_pending <= 1'b0;
      if (clr_pending) wel <= 1'b0;
    end else if (byte_valid) begin
      unique case (state)
        ST_OPC: begin
          unique case (byte_data)
            OP_WREN: begin
              wel   <= 1'b1;
              state <= ST_SKIP;
            end
            OP_WRDI: begin
              clr_pending <= 1'b1;
              state       <= ST_SKIP;
            end
            OP_RDSR: begin
              miso_oe <= 1'b1;
              state   <= ST_SR_RD;
            end
            OP_WRSR: begin
              clr_pending <= 1'b1;
              state       <= ST_SR_WR;
            end
            OP_READ: begin
              is_write <= 1'b0;
              state    <= ST_ADDR_HI;
            end
            OP_WRITE: begin
              is_write    <= 1'b1;
              armed       <= wel;
              clr_pending <= 1'b1;
              state       <= ST_ADDR_HI;
            end
            default: state <= ST_SKIP;
          endcase
        end
        ST_ADDR_HI: begin
          addr[ADDR_W-1:BYTE_W] <= byte_data[HI_W-1:0];
          state <= ST_ADDR_LO;
        end
        ST_ADDR_LO: begin
          if (is_write) begin
            addr[BYTE_W-1:0] <= byte_data;
            state <= ST_WR;
          end else begin
            addr    <= {addr[ADDR_W-1:BYTE_W], byte_data} + 1'b1;
            miso_oe <= 1'b1;
            state   <= ST_RD;
          end
        end
        ST_RD:    addr  <= addr + 1'b1;
        ST_WR:    addr  <= addr + 1'b1;
        ST_SR_WR: state <= ST_SKIP;
        default:  state <= state;
      endcase
    end
  end

  always_comb begin
    tx_load = 1'b0;
    if (take) begin
      unique case (state)
        ST_OPC:     tx_load = (byte_data == OP_RDSR);
        ST_SR_RD:   tx_load = 1'b1;
        ST_ADDR_LO: tx_load = ~is_write;
        ST_RD:      tx_load = 1'b1;
        default:    tx_load = 1'b0;
      endcase
    end
  end

  assign tx_data = (state == ST_OPC || state == ST_SR_RD) ? status_byte : mem_rd_data;
  assign rd_idx  = (state == ST_ADDR_LO) ? lo_idx : addr[MEM_AW-1:0];
  assign mem_we  = take & (state == ST_WR) & armed;
  assign wr_idx  = addr[MEM_AW-1:0];
  assign wr_data = byte_data;

endmodule

// File: rtl/spi_cmd_mem_slave.sv
`timescale 1ns/1ps
module spi_cmd_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int MEM_AW      = 8,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);

  logic              sck_fall;
  logic              cs_active;
  logic              cs_end;
  logic              byte_valid;
  logic [BYTE_W-1:0] byte_data;
  logic              tx_load;
  logic [BYTE_W-1:0] tx_data;
  logic              wel;
  logic              clr_pending;
  ctrl_state_e       ctrl_state;
  logic [ADDR_W-1:0] cur_addr;
  logic              mem_we;
  logic [MEM_AW-1:0] wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [MEM_AW-1:0] rd_idx;
  logic [BYTE_W-1:0] rd_data;

  spi_bit_rx #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) rx_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck        (spi_sck),
    .cs_n       (spi_cs_n),
    .mosi       (spi_mosi),
    .sck_fall   (sck_fall),
    .cs_active  (cs_active),
    .cs_end     (cs_end),
    .byte_valid (byte_valid),
    .byte_data  (byte_data)
  );

  spi_mem_ctrl #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .BYTE_W(BYTE_W)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .cs_end      (cs_end),
    .mem_rd_data (rd_data),
    .tx_load     (tx_load),
    .tx_data     (tx_data),
    .miso_oe     (spi_miso_oe),
    .wel         (wel),
    .clr_pending (clr_pending),
    .state       (ctrl_state),
    .addr        (cur_addr),
    .mem_we      (mem_we),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .rd_idx      (rd_idx)
  );

  spi_mem_store #(.MEM_AW(MEM_AW), .BYTE_W(BYTE_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mem_we),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  spi_byte_tx #(.BYTE_W(BYTE_W)) tx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tx_load),
    .load_data (tx_data),
    .shift     (sck_fall),
    .tx_bit    (spi_miso)
  );

endmodule

// File: rtl/spi_cmd_mem_checker.sv
`timescale 1ns/1ps
module spi_cmd_mem_checker
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_active,
  input logic              cs_end,
  input logic              byte_valid,
  input logic [BYTE_W-1:0] byte_data,
  input logic              wel,
  input logic              clr_pending,
  input ctrl_state_e       ctrl_state,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              mem_we,
  input logic              spi_miso_oe
);

  localparam logic [ADDR_W-1:0] STEP = 1;

  // R11: the output enable drops once the frame has ended
  assert_oe_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> !spi_miso_oe);

  // R4: the arm flag only rises right after an arm op-code byte
  assert_arm_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(byte_valid && byte_data == OP_WREN));

  // R6: frames that disarm leave the flag clear
  assert_arm_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_end && clr_pending) |=> !wel);

  // R7: a store write happens inside a frame and with the flag still set
  assert_write_guarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cs_active && wel));

  // R8: each data byte advances the address by one, modulo 2^ADDR_W
  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !cs_end && (ctrl_state == ST_RD || ctrl_state == ST_WR))
      |=> (cur_addr == $past(cur_addr) + STEP));

  // R9: once ignoring, the controller stays there until the frame ends
  assert_skip_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_state == ST_SKIP && !cs_end) |=> (ctrl_state == ST_SKIP));

endmodule

bind spi_cmd_mem_slave spi_cmd_mem_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_active   (cs_active),
  .cs_end      (cs_end),
  .byte_valid  (byte_valid),
  .byte_data   (byte_data),
  .wel         (wel),
  .clr_pending (clr_pending),
  .ctrl_state  (ctrl_state),
  .cur_addr    (cur_addr),
  .mem_we      (mem_we),
  .spi_miso_oe (spi_miso_oe)
);

// File: tb/spi_cmd_mem_slave_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_mem_slave_tb_top;

  localparam int MEM_AW = 6;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int HALF   = 120;          // six system clocks per serial half period
  localparam int WATCHDOG_CYCLES = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;
  logic miso_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] exp_mem [DEPTH];

  always #10 clk = ~clk;

  spi_cmd_mem_slave #(.ADDR_W(13), .MEM_AW(MEM_AW), .BYTE_W(8), .SYNC_STAGES(2)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sck     (sck),
    .spi_cs_n    (cs_n),
    .spi_mosi    (mosi),
    .spi_miso    (miso),
    .spi_miso_oe (miso_oe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] d, input int nbits, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = d[i];
      #(HALF);
      r[i] = miso;
      sck = 1'b1;
      #(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] r);
    xbits(d, 8, r);
  endtask

  task automatic fr_open();
    cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic fr_close();
    #(HALF);
    cs_n = 1'b1;
    #(4 * HALF);
  endtask

  task automatic single(input logic [7:0] op);
    logic [7:0] r;
    fr_open(); xfer(op, r); fr_close();
  endtask

  task automatic read_status(output logic [7:0] s);
    logic [7:0] r;
    fr_open(); xfer(8'h05, r); xfer(8'h00, s); fr_close();
  endtask

  task automatic open_mem(input logic [7:0] op, input logic [15:0] a);
    logic [7:0] r;
    fr_open(); xfer(op, r); xfer(a[15:8], r); xfer(a[7:0], r);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] r;
    logic [7:0] s;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;

    repeat (4) @(posedge clk);
    #5;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;

    // R11, R3: idle state after reset
    check("R11 oe idle after reset", {7'b0, miso_oe}, 8'h00);
    read_status(s);
    check("R3 status after reset", s, 8'h00);

    // R7: memory write without arming leaves the store alone
    open_mem(8'h02, 16'h0000); xfer(8'hAA, r); xfer(8'hAB, r); fr_close();
    open_mem(8'h03, 16'h0000);
    xfer(8'h00, r); check("R7 unarmed write loc0", r, 8'h00);
    xfer(8'h00, r); check("R7 unarmed write loc1", r, 8'h00);
    fr_close();

    // R4, R11: arm and read status twice in one frame
    single(8'h06);
    fr_open(); xfer(8'h05, r);
    check("R11 oe during status read", {7'b0, miso_oe}, 8'h01);
    xfer(8'h00, s); check("R4 armed status", s, 8'h02);
    xfer(8'h00, s); check("R4 armed status repeat", s, 8'h02);
    fr_close();
    check("R11 oe released after frame", {7'b0, miso_oe}, 8'h00);

    // R6: disarm op-code
    single(8'h04);
    read_status(s); check("R6 after disarm", s, 8'h00);

    // R5, R6: status write paths
    fr_open(); xfer(8'h01, r); xfer(8'h02, r); fr_close();
    read_status(s); check("R5 status write cannot arm", s, 8'h00);
    single(8'h06);
    fr_open(); xfer(8'h01, r); xfer(8'hFF, r); fr_close();
    read_status(s); check("R6 status write clears arm", s, 8'h00);

    // R7, R8, R1, R6: full sweep write then read
    single(8'h06);
    open_mem(8'h02, 16'h0000);
    for (int a = 0; a < DEPTH; a++) begin
      xfer(pat(a), r);
      exp_mem[a] = pat(a);
    end
    fr_close();
    read_status(s); check("R6 memory write clears arm", s, 8'h00);
    open_mem(8'h03, 16'h0000);
    for (int a = 0; a < DEPTH; a++) begin
      xfer(8'h00, r);
      check($sformatf("R1 R8 sweep read loc %0d", a), r, exp_mem[a]);
    end
    fr_close();

    // R8: top three address bits ignored
    open_mem(8'h03, 16'hE003);
    xfer(8'h00, r); check("R8 high bits ignored first", r, exp_mem[3]);
    xfer(8'h00, r); check("R8 high bits ignored next", r, exp_mem[4]);
    fr_close();

    // R12: alias above the storage depth
    open_mem(8'h03, 16'h0045);
    xfer(8'h00, r); check("R12 alias 0x45", r, exp_mem[5]);
    fr_close();

    // R8: wrap from the last address to zero
    single(8'h06);
    open_mem(8'h02, 16'h1FFF); xfer(8'h5A, r); xfer(8'hC3, r); fr_close();
    exp_mem[DEPTH-1] = 8'h5A;
    exp_mem[0] = 8'hC3;
    open_mem(8'h03, 16'h1FFF);
    xfer(8'h00, r); check("R8 last address", r, 8'h5A);
    xfer(8'h00, r); check("R8 wrapped to zero", r, 8'hC3);
    fr_close();

    // R10: frame aborted inside a data byte
    single(8'h06);
    open_mem(8'h02, 16'h0010); xfer(8'h77, r); xbits(8'h0F, 4, r); fr_close();
    exp_mem[16] = 8'h77;
    open_mem(8'h03, 16'h0010);
    xfer(8'h00, r); check("R10 full byte kept", r, exp_mem[16]);
    xfer(8'h00, r); check("R10 partial byte dropped", r, exp_mem[17]);
    fr_close();
    read_status(s); check("R6 aborted write clears arm", s, 8'h00);

    // R7: write after the flag was consumed has no effect
    open_mem(8'h02, 16'h0020); xfer(8'h00, r); fr_close();
    open_mem(8'h03, 16'h0020);
    xfer(8'h00, r); check("R7 rearm required", r, exp_mem[32]);
    fr_close();

    // R10: partial op-code does not shift the next frame
    fr_open(); xbits(8'h06, 7, r); fr_close();
    read_status(s); check("R10 partial opcode dropped", s, 8'h00);
    single(8'h06);
    read_status(s); check("R10 R2 realigned arm", s, 8'h02);
    single(8'h04);

    // R9, R11, R2: every undefined op-code ignores the rest of its frame
    for (int op = 0; op < 256; op++) begin
      if (op >= 1 && op <= 6) continue;
      fr_open();
      xfer(8'(op), r);
      check($sformatf("R11 oe after undefined %02h", op), {7'b0, miso_oe}, 8'h00);
      xfer(8'h06, r);
      fr_close();
      read_status(s);
      check($sformatf("R9 ignored after %02h", op), s, 8'h00);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule